// File: doc/BRIEF.md
# Timed Digital Pattern Sequencer

The sequencer replays a list of timed level patterns onto a bank of digital output lines. Each command carries a scheduled time, a level word and a one-bit end marker. Commands arrive over a single valid/ready stream, and one sequencing loop serves every line. A free-running cycle counter starts at zero on a start pulse. A command's levels are driven once that counter has reached the command's time. The command flagged as final ends playback.

A holding register sits between the stream and the wide time comparison, so a stream read and the comparison never share a clock cycle. The level word leaves the block as whole byte-wide port words. There is no per-line decode.

Back-pressure rules: `cmd_ready` is high only while the block is running and its single holding slot is empty. A command moves only on a clock edge where `cmd_valid` and `cmd_ready` are both high. The source may raise or lower `cmd_valid` at any time. While `cmd_valid` is high, the command fields must be stable.

Top module: `pattern_sequencer`

## Requirements
- R1: After reset, every port word is zero, `status` is 0 (idle), `cmd_ready` is low and `underflow` is low.
- R2: A `start` pulse seen while idle (0) or done (2) enters running (1), clears the time counter to zero and clears `underflow`. A `start` pulse seen while running has no effect on any output.
- R3: `cmd_ready` is high exactly when `status` is running and no accepted command is still waiting. At most one command is held at a time.
- R4: A command accepted on clock edge k cannot change the outputs before edge k+1.
- R5: The time counter reads 0 in the first running cycle and then rises by one per running cycle. A held command with time T is applied on the first edge at which the counter value in the preceding cycle is greater than or equal to T, using an unsigned comparison.
- R6: A command whose time has already passed when it is accepted is applied on the very next edge.
- R7: Bits 8k+7 down to 8k of the level word drive port word k, so bit n of the word drives line n. Port words hold their value between applied commands.
- R8: A command with `cmd_last` set has its levels applied at its time like any other command, and then `status` becomes done (2). While done, `cmd_ready` stays low, incoming commands are left unread and the outputs hold.
- R9: `underflow` becomes set when the block is running, the slot is empty and `cmd_valid` is low. Once set, it stays set until the next accepted `start`. Playback continues when it is set.
- R10: `status` uses the encoding 0 = idle, 1 = running and 2 = done. It never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse: begin playback, clear the counter |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_last | input | 1 | End marker of the command |
| cmd_time | input | TIME_W (32) | Scheduled cycle of the command |
| cmd_levels | input | N_PORTS*PORT_W (32) | Level word, bit n for line n |
| dout | output | N_PORTS x PORT_W (4x8) | Byte-wide output port words |
| status | output | 2 | 0 idle, 1 running, 2 done |
| underflow | output | 1 | Sticky flag: the stream ran dry during playback |

## Verification
The bench targets several failure modes:
- Time zero and times already in the past. A design that compared against a stale or next-cycle counter would apply these a cycle early or late.
- The edge just after a pop. A design that bypassed the holding register would change the outputs on that edge.
- Back-pressure from a source that stalls at random, and the end marker followed by further queued commands. A design that kept reading after done would alter the outputs.
- A start pulse in the middle of a run, which a faulty design would honour by resetting the counter.
- Underflow that must survive until the next accepted start.

// File: rtl/patseq_pkg.sv
package patseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/patseq_ctrl.sv
module patseq_ctrl
  import patseq_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fin_i,
  input  logic              starve_i,
  output seq_state_e        state_o,
  output logic [TIME_W-1:0] now_o,
  output logic              underflow_o
);
  seq_state_e        state_q;
  logic [TIME_W-1:0] now_q;
  logic              uf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      now_q   <= '0;
      uf_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            now_q   <= '0;
            uf_q    <= 1'b0;
          end
        end
        ST_RUN: begin
          now_q <= now_q + 1'b1;
          if (starve_i) uf_q <= 1'b1;
          if (fin_i) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign now_o       = now_q;
  assign underflow_o = uf_q;

  // R5: the counter advances by one on every running cycle
  a_r5_time_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> (now_q == $past(now_q) + 1'b1));

  // R9: the flag is held until a start pulse
  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && !start_i) |=> uf_q);

  // R10: only the three legal encodings
  a_r10_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != 2'd3));
endmodule

// File: rtl/patseq_stage.sv
module patseq_stage #(
  parameter int TIME_W = 32,
  parameter int CH_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_last_i,
  input  logic [TIME_W-1:0] cmd_time_i,
  input  logic [CH_W-1:0]   cmd_levels_i,
  input  logic              consume_i,
  output logic              ready_o,
  output logic              starve_o,
  output logic              held_o,
  output logic              h_last_o,
  output logic [TIME_W-1:0] h_time_o,
  output logic [CH_W-1:0]   h_levels_o
);
  logic              held_q;
  logic              last_q;
  logic [TIME_W-1:0] time_q;
  logic [CH_W-1:0]   lev_q;
  logic              take;

  assign ready_o  = run_i & ~held_q;
  assign take     = ready_o & cmd_valid_i;
  assign starve_o = ready_o & ~cmd_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      last_q <= 1'b0;
      time_q <= '0;
      lev_q  <= '0;
    end else if (take) begin
      held_q <= 1'b1;
      last_q <= cmd_last_i;
      time_q <= cmd_time_i;
      lev_q  <= cmd_levels_i;
    end else if (consume_i) begin
      held_q <= 1'b0;
    end
  end

  assign held_o     = held_q;
  assign h_last_o   = last_q;
  assign h_time_o   = time_q;
  assign h_levels_o = lev_q;

  // R3: the consumer only releases a command that is actually held
  a_r3_consume_held: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |-> held_q);
endmodule

// File: rtl/patseq_cmp.sv
module patseq_cmp #(
  parameter int TIME_W = 32
) (
  input  logic              held_i,
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] due_time_i,
  output logic              due_o
);
  assign due_o = held_i & (now_i >= due_time_i);
endmodule

// File: rtl/patseq_ports.sv
module patseq_ports #(
  parameter int N_PORTS = 4,
  parameter int PORT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [N_PORTS*PORT_W-1:0]     levels_i,
  output logic [N_PORTS-1:0][PORT_W-1:0] port_o
);
  for (genvar k = 0; k < N_PORTS; k++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)      port_o[k] <= '0;
      else if (load_i) port_o[k] <= levels_i[k*PORT_W +: PORT_W];
    end
  end

  // R7: port words hold between loads
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(port_o));
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
  import patseq_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int PORT_W  = 8,
  parameter int TIME_W  = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic                           cmd_last,
  input  logic [TIME_W-1:0]              cmd_time,
  input  logic [N_PORTS*PORT_W-1:0]      cmd_levels,
  output logic [N_PORTS-1:0][PORT_W-1:0] dout,
  output logic [1:0]                     status,
  output logic                           underflow
);
  localparam int CH_W = N_PORTS * PORT_W;

  seq_state_e        state;
  logic [TIME_W-1:0] now;
  logic              starve, held, h_last, due, fin;
  logic [TIME_W-1:0] h_time;
  logic [CH_W-1:0]   h_levels;

  assign fin = due & h_last;

  patseq_ctrl #(.TIME_W(TIME_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fin_i(fin),
    .starve_i(starve), .state_o(state), .now_o(now), .underflow_o(underflow)
  );

  patseq_stage #(.TIME_W(TIME_W), .CH_W(CH_W)) i_stage (
    .clk(clk), .rst_n(rst_n), .run_i(state == ST_RUN),
    .cmd_valid_i(cmd_valid), .cmd_last_i(cmd_last), .cmd_time_i(cmd_time),
    .cmd_levels_i(cmd_levels), .consume_i(due), .ready_o(cmd_ready),
    .starve_o(starve), .held_o(held), .h_last_o(h_last),
    .h_time_o(h_time), .h_levels_o(h_levels)
  );

  patseq_cmp #(.TIME_W(TIME_W)) i_cmp (
    .held_i(held), .now_i(now), .due_time_i(h_time), .due_o(due)
  );

  patseq_ports #(.N_PORTS(N_PORTS), .PORT_W(PORT_W)) i_ports (
    .clk(clk), .rst_n(rst_n), .load_i(due), .levels_i(h_levels), .port_o(dout)
  );

  assign status = state;

  // R3: the stream is only accepted while running
  a_r3_ready_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (state == ST_RUN));

  // R4: an accepted command cannot reach the ports on the next edge
  a_r4_stage_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> $stable(dout));

  // R8: nothing is read after the final command
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> !cmd_ready);
endmodule

// File: tb/test_pattern_sequencer.sv
module test_pattern_sequencer;
  localparam int NP = 4, PW = 8, TW = 32;

  typedef struct {
    bit          last;
    int unsigned t;
    int unsigned lv;
  } cmd_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst_n = 1'b0, start = 1'b0;
  logic                   cmd_valid = 1'b0, cmd_ready, cmd_last = 1'b0;
  logic [TW-1:0]          cmd_time = '0;
  logic [NP*PW-1:0]       cmd_levels = '0;
  logic [NP-1:0][PW-1:0]  dout;
  logic [1:0]             status;
  logic                   underflow;

  pattern_sequencer #(.N_PORTS(NP), .PORT_W(PW), .TIME_W(TW)) i_pattern_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_last(cmd_last), .cmd_time(cmd_time),
    .cmd_levels(cmd_levels), .dout(dout), .status(status), .underflow(underflow)
  );

  cmd_t        q[$];
  bit          stall_mode = 0, stall = 0;
  int          m_state = 0;
  int unsigned m_cnt = 0, m_port = 0;
  bit          m_hv = 0, m_uf = 0;
  cmd_t        m_h;
  int          checks = 0, fails = 0, cyc = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit rdy;
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_hv = 0; m_uf = 0; m_port = 0;
    end else begin
      rdy = (m_state == 1) && !m_hv;
      if (start && m_state != 1) begin
        m_state = 1; m_cnt = 0; m_uf = 0;
      end else if (m_state == 1) begin
        if (m_hv && m_cnt >= m_h.t) begin
          m_port = m_h.lv; m_hv = 0;
          if (m_h.last) m_state = 2;
        end else if (rdy) begin
          if (cmd_valid) begin m_h = q.pop_front(); m_hv = 1; end
          else m_uf = 1;
        end
        m_cnt++;
      end
    end
  end

  // compare on the falling edge, then drive the stream
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(32'(dout) == m_port, "R5", "port words (R7 mapping)", 32'(dout), m_port);
      chk(status == 2'(m_state), "R10", "status", status, m_state);
      chk(cmd_ready == ((m_state == 1) && !m_hv), "R3", "cmd_ready", cmd_ready, (m_state == 1) && !m_hv);
      chk(underflow == m_uf, "R9", "underflow", underflow, m_uf);
    end
    stall     = stall_mode && ($urandom_range(0, 3) == 0);
    cmd_valid = (q.size() != 0) && !stall;
    if (q.size() != 0) begin
      cmd_last = q[0].last; cmd_time = q[0].t; cmd_levels = q[0].lv;
    end else begin
      cmd_last = 0; cmd_time = '0; cmd_levels = '0;
    end
  end

  task automatic push(bit last, int unsigned t, int unsigned lv);
    cmd_t c;
    c.last = last; c.t = t; c.lv = lv;
    q.push_back(c);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && status != 2'd2; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(32'(dout) == 0, "R1", "reset dout", 32'(dout), 0);
    chk(status == 2'd0, "R1", "reset status", status, 0);
    chk(cmd_ready == 1'b0, "R1", "reset ready", cmd_ready, 0);
    chk(underflow == 1'b0, "R1", "reset underflow", underflow, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // run 1: directed timing
    push(0, 0, 32'h11223344);
    pulse_start();
    chk(status == 2'd1, "R2", "status after start", status, 1);
    @(negedge clk);  // command popped on this edge
    chk(32'(dout) == 0, "R4", "ports one edge after pop", 32'(dout), 0);
    @(negedge clk);
    chk(32'(dout) == 32'h11223344, "R6", "past-time command applied next edge", 32'(dout), 32'h11223344);
    chk(dout[0] == 8'h44 && dout[3] == 8'h11, "R7", "byte 0 / byte 3", {dout[3], dout[0]}, 16'h1144);
    push(0, 10, 32'hA5A50F0F);
    push(0, 10, 32'h00FF00FF);
    push(1, 40, 32'hDEADBEEF);
    wait_done();
    chk(status == 2'd2, "R8", "done after end marker", status, 2);
    chk(32'(dout) == 32'hDEADBEEF, "R8", "final levels applied", 32'(dout), 32'hDEADBEEF);
    push(0, 0, 32'h12345678);
    repeat (6) @(negedge clk);
    chk(32'(dout) == 32'hDEADBEEF, "R8", "queued command ignored after done", 32'(dout), 32'hDEADBEEF);
    chk(cmd_ready == 1'b0, "R8", "ready low while done", cmd_ready, 0);

    // run 2: underflow and start during run
    pulse_start();
    repeat (10) @(negedge clk);
    chk(underflow == 1'b1, "R9", "underflow after stream ran dry", underflow, 1);
    pulse_start();
    chk(status == 2'd1, "R2", "start while running ignored", status, 1);
    chk(underflow == 1'b1, "R9", "flag kept over ignored start", underflow, 1);
    push(1, 5, 32'hCAFEF00D);
    wait_done();
    chk(32'(dout) == 32'hCAFEF00D, "R8", "run 2 end levels", 32'(dout), 32'hCAFEF00D);

    // run 3: random times with random stalls
    begin
      int unsigned tc = 0;
      for (int i = 0; i < 120; i++) begin
        tc += $urandom_range(0, 6);
        push(i == 119, ($urandom_range(0, 4) == 0) ? $urandom_range(0, tc) : tc, $urandom);
      end
    end
    stall_mode = 1;
    pulse_start();
    chk(underflow == 1'b0, "R2", "start clears underflow", underflow, 0);
    wait_done();
    chk(status == 2'd2, "R8", "random run reached done", status, 2);
    stall_mode = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule